// File: doc/BRIEF.md
# Power-Fail Protected Byte-Lane SRAM

This block is a synthesizable static memory, by default two 8-bit byte lanes wide, with active-low per-lane select inputs, an active-low write strobe and an active-low read enable. Each byte lane is stored and driven on its own. A read drives only the selected lanes. A write stores only the selected lanes. A write completes when its strobe window closes. That happens when the write strobe rises or when any lane that took part deselects, whichever comes first.

A supply supervisor sits in front of the array. Three digital flags come from external comparators: supply above the operating level, supply at or below the protect level, and supply below the battery switch-over level. The flags pass through a short synchronizer. A four-state mode machine then decides whether accesses are honoured. While protected, every access input is ignored and no lane drives. Protection is held for a programmable recovery count after the supply returns. The machine also engages the backup source when the switch-over flag is set.

A one-time shipping seal keeps the backup source disconnected until the supply is first seen good. After that the seal stays broken, and stored contents are reported valid and survive later supply losses.

Top module: `sram_pf_top`

## Requirements
- R1: A read (write strobe high, read enable low, access allowed) drives exactly the lanes whose select is low, each with the byte stored at `addr_i` for that lane (lane k is bits 8k+7..8k). Deselected lanes have their drive bit at 0 and their data bits at 0.
- R2: A write stores only the lanes whose select was low during the strobe window. The other lanes of that word keep their previous contents.
- R3: A write commits when the write strobe rises or when any participating lane select rises, whichever is first. If a select rise ended it, no new write starts until the write strobe has been high for at least one clock.
- R4: While the write strobe is low, no lane drives, even with the read enable and a select low.
- R5: If the supply-good flag falls, or the protect flag rises, then within FAIL_DLY clocks the mode leaves normal. From then on all lane drives are 0 and write attempts leave memory unchanged.
- R6: Once the seal is broken, `backup_on_o` is 1 exactly while the mode is backup. That mode is entered when the synchronized switch-over flag is set, and left to protected when the flag clears.
- R7: When the mode is protected, the mode returns to normal only after REC_CYC consecutive clocks in which the synchronized flags show a good supply. With SYNC_STAGES=2 that is the 7th clock edge after the flags become good.
- R8: After reset the mode is sealed, and `backup_on_o` stays 0 even with the switch-over flag set. The first good supply breaks the seal, and the mode never returns to sealed.
- R9: `data_valid_o` is 0 while sealed and 1 once the seal is broken. Contents written after that are unchanged across a protect/backup/recovery sequence.
- R10: `mode_o` encodes sealed as 0, normal as 1, protected as 2 and backup as 3.
- R11: During and right after reset, all lane drives, `backup_on_o` and `data_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_ok_i | input | 1 | Supply above operating level |
| pwr_prot_i | input | 1 | Supply at or below protect level |
| pwr_bat_i | input | 1 | Supply below battery switch-over level |
| sel_n_i | input | LANES | Active-low byte lane selects (bit 0 lower lane) |
| wr_n_i | input | 1 | Active-low write strobe |
| rd_n_i | input | 1 | Active-low read enable |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | LANES*LANE_W | Write data |
| rdata_o | output | LANES*LANE_W | Read data; undriven lanes read 0 |
| lane_drive_o | output | LANES | Per-lane output drive enable (0 means high impedance) |
| backup_on_o | output | 1 | Backup source engaged |
| data_valid_o | output | 1 | Stored contents are valid |
| mode_o | output | 2 | Current mode code |

## Verification
The bench builds the block with an 8-word depth (ADDR_W=3), two 8-bit lanes, REC_CYC=4, SYNC_STAGES=2 and FAIL_DLY=4. The small depth allows a sweep of every address against every write lane mask and every read lane mask, compared against an arithmetic model of the array. The short recovery count puts the exact protected-to-normal edge within a few clocks, so it can be checked on both sides. The bench also drives the full supply sequence: sealed, good supply, brownout, backup, and return. It checks that contents written before that sequence are still present afterwards.

// File: rtl/sram_pf_pkg.sv
package sram_pf_pkg;

   typedef enum logic [1:0] {
      MODE_SEALED = 2'd0,
      MODE_NORMAL = 2'd1,
      MODE_PROT   = 2'd2,
      MODE_BACKUP = 2'd3
   } pf_mode_e;

   typedef struct packed {
      logic ok;
      logic prot;
      logic bat;
   } pf_flags_t;

   localparam pf_flags_t FLAGS_DEAD = '{ok: 1'b0, prot: 1'b1, bat: 1'b1};

endpackage

// File: rtl/sram_pf_sync.sv
module sram_pf_sync
   import sram_pf_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic      clk_i,
   input  logic      rst_ni,
   input  pf_flags_t raw_i,
   output pf_flags_t sync_o
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign sync_o = raw_i;
      end else begin : g_pipe
         pf_flags_t pipe_q [STAGES];

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               for (int i = 0; i < STAGES; i++) pipe_q[i] <= FLAGS_DEAD;
            end else begin
               pipe_q[0] <= raw_i;
               for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
            end
         end

         assign sync_o = pipe_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/sram_pf_supervisor.sv
module sram_pf_supervisor
   import sram_pf_pkg::*;
#(
   parameter int REC_CYC = 4
) (
   input  logic      clk_i,
   input  logic      rst_ni,
   input  pf_flags_t flg_i,
   output pf_mode_e  mode_o,
   output logic      access_ok_o
);

   localparam int CW = $clog2(REC_CYC + 1);

   pf_mode_e        st_q, st_d;
   logic [CW-1:0]   cnt_q, cnt_d;
   logic            supply_good;

   assign supply_good = flg_i.ok & ~flg_i.prot;

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      unique case (st_q)
         MODE_SEALED: begin
            if (supply_good) begin
               st_d  = MODE_PROT;
               cnt_d = CW'(1);
            end
         end
         MODE_NORMAL: begin
            if (!supply_good) begin
               st_d  = flg_i.bat ? MODE_BACKUP : MODE_PROT;
               cnt_d = '0;
            end
         end
         MODE_PROT: begin
            if (flg_i.bat) begin
               st_d  = MODE_BACKUP;
               cnt_d = '0;
            end else if (!supply_good) begin
               cnt_d = '0;
            end else if (cnt_q == CW'(REC_CYC)) begin
               st_d  = MODE_NORMAL;
               cnt_d = '0;
            end else begin
               cnt_d = cnt_q + CW'(1);
            end
         end
         MODE_BACKUP: begin
            if (!flg_i.bat) begin
               st_d  = MODE_PROT;
               cnt_d = '0;
            end
         end
         default: begin
            st_d  = MODE_PROT;
            cnt_d = '0;
         end
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q  <= MODE_SEALED;
         cnt_q <= '0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
      end
   end

   assign mode_o      = st_q;
   assign access_ok_o = (st_q == MODE_NORMAL);

endmodule

// File: rtl/sram_pf_wctl.sv
module sram_pf_wctl #(
   parameter int LANES  = 2,
   parameter int LANE_W = 8,
   parameter int ADDR_W = 6,
   localparam int DW    = LANES * LANE_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              access_ok_i,
   input  logic [LANES-1:0]  sel_n_i,
   input  logic              wr_n_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DW-1:0]     wdata_i,
   output logic              commit_o,
   output logic [LANES-1:0]  commit_lanes_o,
   output logic [ADDR_W-1:0] commit_addr_o,
   output logic [DW-1:0]     commit_data_o
);

   logic              act_q, blocked_q;
   logic [LANES-1:0]  lanes_q, lanes_now;
   logic [ADDR_W-1:0] addr_q;
   logic [DW-1:0]     data_q;
   logic              end_now, start_ok;

   assign lanes_now = ~sel_n_i & {LANES{~wr_n_i}};
   assign start_ok  = access_ok_i & ~blocked_q & (|lanes_now);
   assign end_now   = act_q & (wr_n_i | (|(lanes_q & sel_n_i)));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         act_q     <= 1'b0;
         blocked_q <= 1'b0;
         lanes_q   <= '0;
         addr_q    <= '0;
         data_q    <= '0;
      end else begin
         if (wr_n_i) blocked_q <= 1'b0;
         if (end_now) begin
            act_q <= 1'b0;
            if (!wr_n_i) blocked_q <= 1'b1;
         end else if (!access_ok_i) begin
            act_q <= 1'b0;
         end else if (start_ok) begin
            act_q   <= 1'b1;
            lanes_q <= lanes_now;
            addr_q  <= addr_i;
            data_q  <= wdata_i;
         end
      end
   end

   assign commit_o       = end_now & access_ok_i;
   assign commit_lanes_o = lanes_q;
   assign commit_addr_o  = addr_q;
   assign commit_data_o  = data_q;

endmodule

// File: rtl/sram_pf_array.sv
module sram_pf_array #(
   parameter int LANES  = 2,
   parameter int LANE_W = 8,
   parameter int ADDR_W = 6,
   localparam int DW    = LANES * LANE_W,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk_i,
   input  logic              commit_i,
   input  logic [LANES-1:0]  commit_lanes_i,
   input  logic [ADDR_W-1:0] commit_addr_i,
   input  logic [DW-1:0]     commit_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   input  logic [LANES-1:0]  drive_i,
   output logic [DW-1:0]     rdata_o
);

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic [LANE_W-1:0] mem [DEPTH];

         always_ff @(posedge clk_i) begin
            if (commit_i && commit_lanes_i[g])
               mem[commit_addr_i] <= commit_data_i[g*LANE_W +: LANE_W];
         end

         assign rdata_o[g*LANE_W +: LANE_W] = drive_i[g] ? mem[rd_addr_i] : '0;
      end
   endgenerate

endmodule

// File: rtl/sram_pf_top.sv
module sram_pf_top
   import sram_pf_pkg::*;
#(
   parameter int LANES       = 2,
   parameter int LANE_W      = 8,
   parameter int ADDR_W      = 6,
   parameter int REC_CYC     = 16,
   parameter int SYNC_STAGES = 2,
   parameter int FAIL_DLY    = 4,
   localparam int DW         = LANES * LANE_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              pwr_ok_i,
   input  logic              pwr_prot_i,
   input  logic              pwr_bat_i,
   input  logic [LANES-1:0]  sel_n_i,
   input  logic              wr_n_i,
   input  logic              rd_n_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DW-1:0]     wdata_i,
   output logic [DW-1:0]     rdata_o,
   output logic [LANES-1:0]  lane_drive_o,
   output logic              backup_on_o,
   output logic              data_valid_o,
   output logic [1:0]        mode_o
);

   generate
      if (LANES < 1)                     begin : g_bad_lanes $error("LANES must be at least 1"); end
      if (LANE_W < 1)                    begin : g_bad_lw    $error("LANE_W must be at least 1"); end
      if (ADDR_W < 1 || ADDR_W > 12)     begin : g_bad_aw    $error("ADDR_W out of range"); end
      if (REC_CYC < 1)                   begin : g_bad_rec   $error("REC_CYC must be at least 1"); end
      if (SYNC_STAGES + 1 > FAIL_DLY)    begin : g_bad_dly   $error("fail-detect latency exceeds FAIL_DLY"); end
   endgenerate

   pf_flags_t         flags_raw, flags_s;
   pf_mode_e          mode;
   logic              access_ok;
   logic              commit;
   logic [LANES-1:0]  commit_lanes;
   logic [ADDR_W-1:0] commit_addr;
   logic [DW-1:0]     commit_data;
   logic [LANES-1:0]  drive;

   assign flags_raw = '{ok: pwr_ok_i, prot: pwr_prot_i, bat: pwr_bat_i};

   sram_pf_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (flags_raw),
      .sync_o (flags_s)
   );

   sram_pf_supervisor #(.REC_CYC(REC_CYC)) u_sup (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .flg_i       (flags_s),
      .mode_o      (mode),
      .access_ok_o (access_ok)
   );

   sram_pf_wctl #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_wctl (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .access_ok_i    (access_ok),
      .sel_n_i        (sel_n_i),
      .wr_n_i         (wr_n_i),
      .addr_i         (addr_i),
      .wdata_i        (wdata_i),
      .commit_o       (commit),
      .commit_lanes_o (commit_lanes),
      .commit_addr_o  (commit_addr),
      .commit_data_o  (commit_data)
   );

   assign drive = (access_ok & wr_n_i & ~rd_n_i) ? ~sel_n_i : '0;

   sram_pf_array #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_array (
      .clk_i          (clk_i),
      .commit_i       (commit),
      .commit_lanes_i (commit_lanes),
      .commit_addr_i  (commit_addr),
      .commit_data_i  (commit_data),
      .rd_addr_i      (addr_i),
      .drive_i        (drive),
      .rdata_o        (rdata_o)
   );

   assign lane_drive_o = drive;
   assign backup_on_o  = (mode == MODE_BACKUP);
   assign data_valid_o = (mode != MODE_SEALED);
   assign mode_o       = mode;

endmodule

// File: rtl/sram_pf_chk.sv
module sram_pf_chk #(
   parameter int LANES    = 2,
   parameter int FAIL_DLY = 4
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             pwr_ok_i,
   input logic             pwr_prot_i,
   input logic             wr_n_i,
   input logic [LANES-1:0] sel_n_i,
   input logic [LANES-1:0] lane_drive_o,
   input logic             backup_on_o,
   input logic             data_valid_o,
   input logic [1:0]       mode_o
);

   localparam int FCW = $clog2(FAIL_DLY + 2);
   localparam logic [1:0] M_SEALED = 2'd0;
   localparam logic [1:0] M_NORMAL = 2'd1;
   localparam logic [1:0] M_PROT   = 2'd2;

   logic [FCW-1:0] fail_cnt;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) fail_cnt <= '0;
      else if ((!pwr_ok_i || pwr_prot_i) && mode_o == M_NORMAL) begin
         if (fail_cnt != {FCW{1'b1}}) fail_cnt <= fail_cnt + FCW'(1);
      end else fail_cnt <= '0;
   end

   AST_LANE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lane_drive_o & sel_n_i) == '0);                                             // R1
   AST_WE_MUTES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_n_i |-> lane_drive_o == '0);                                             // R4
   AST_PROT_MUTES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_o != M_NORMAL |-> lane_drive_o == '0);                                  // R5
   AST_FAIL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fail_cnt <= FCW'(FAIL_DLY));                                                 // R5
   AST_BACKUP_UNSEALED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      backup_on_o |-> data_valid_o);                                               // R6
   AST_REC_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o == M_NORMAL && $past(mode_o) != M_NORMAL) |-> $past(mode_o) == M_PROT); // R7
   AST_NO_RESEAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_o != M_SEALED |=> mode_o != M_SEALED);                                  // R8
   AST_VALID_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      data_valid_o |=> data_valid_o);                                              // R9

endmodule

bind sram_pf_top sram_pf_chk #(.LANES(LANES), .FAIL_DLY(FAIL_DLY)) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .pwr_ok_i     (pwr_ok_i),
   .pwr_prot_i   (pwr_prot_i),
   .wr_n_i       (wr_n_i),
   .sel_n_i      (sel_n_i),
   .lane_drive_o (lane_drive_o),
   .backup_on_o  (backup_on_o),
   .data_valid_o (data_valid_o),
   .mode_o       (mode_o)
);

// File: tb/sram_pf_top_tb.sv
module sram_pf_top_tb_top;

   localparam int AW = 3;
   localparam int NW = 1 << AW;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pok = 1'b0, pprot = 1'b1, pbat = 1'b1;
   logic [1:0]  sel_n = 2'b11;
   logic        wr_n = 1'b1, rd_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic [1:0]  drive;
   logic        bkp, valid;
   logic [1:0]  mode;

   logic [15:0] mdl [NW];
   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   sram_pf_top #(
      .LANES(2), .LANE_W(8), .ADDR_W(AW), .REC_CYC(4), .SYNC_STAGES(2), .FAIL_DLY(4)
   ) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .pwr_ok_i(pok), .pwr_prot_i(pprot), .pwr_bat_i(pbat),
      .sel_n_i(sel_n), .wr_n_i(wr_n), .rd_n_i(rd_n), .addr_i(addr), .wdata_i(wdata),
      .rdata_o(rdata), .lane_drive_o(drive), .backup_on_o(bkp), .data_valid_o(valid),
      .mode_o(mode)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic set_pwr(input logic ok, input logic prot, input logic bat);
      pok = ok; pprot = prot; pbat = bat;
   endtask

   function automatic logic [15:0] lane_mask(input logic [1:0] sn);
      return {{8{~sn[1]}}, {8{~sn[0]}}};
   endfunction

   task automatic do_write(input logic [AW-1:0] a, input logic [15:0] d,
                           input logic [1:0] sn, input bit upd);
      addr = a; wdata = d; sel_n = sn; wr_n = 1'b0; rd_n = 1'b1;
      step(1);
      wr_n = 1'b1; sel_n = 2'b11;
      step(1);
      if (upd) mdl[a] = (mdl[a] & ~lane_mask(sn)) | (d & lane_mask(sn));
   endtask

   task automatic chk_read(input logic [AW-1:0] a, input logic [1:0] sn, input string req);
      addr = a; sel_n = sn; wr_n = 1'b1; rd_n = 1'b0;
      #1;
      check({req, " drive"}, {30'd0, drive}, {30'd0, ~sn});
      check({req, " data"},  {16'd0, rdata}, {16'd0, mdl[a] & lane_mask(sn)});
      rd_n = 1'b1; sel_n = 2'b11;
   endtask

   task automatic chk_dark(input logic [AW-1:0] a, input string req);
      addr = a; sel_n = 2'b00; wr_n = 1'b1; rd_n = 1'b0;
      #1;
      check({req, " no drive"}, {30'd0, drive}, 32'd0);
      check({req, " data zero"}, {16'd0, rdata}, 32'd0);
      rd_n = 1'b1; sel_n = 2'b11;
   endtask

   initial begin
      #(5.0 * 150000);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < NW; i++) mdl[i] = '0;
      step(3);
      // R11 reset state, R10 code for sealed
      check("R11 drive", {30'd0, drive}, 32'd0);
      check("R11 backup", {31'd0, bkp}, 32'd0);
      check("R11 valid", {31'd0, valid}, 32'd0);
      check("R10 sealed code", {30'd0, mode}, 32'd0);
      rst_n = 1'b1;
      step(6);
      // R8 seal keeps backup off although switch-over flag is set
      check("R8 sealed backup off", {31'd0, bkp}, 32'd0);
      check("R8 still sealed", {30'd0, mode}, 32'd0);
      check("R9 invalid while sealed", {31'd0, valid}, 32'd0);
      chk_dark(0, "R8 no access while sealed");

      // R7 first good supply: protected for REC_CYC, normal on edge 7
      set_pwr(1'b1, 1'b0, 1'b0);
      step(3);
      check("R10 protected code", {30'd0, mode}, 32'd2);
      check("R9 valid after seal break", {31'd0, valid}, 32'd1);
      step(3);
      check("R7 still protected", {30'd0, mode}, 32'd2);
      step(1);
      check("R10 normal code", {30'd0, mode}, 32'd1);

      // R1 R2 sweep: full word per address, then each lane mask, read each mask
      for (int a = 0; a < NW; a++)
         do_write(AW'(a), 16'h1357 ^ (16'(a) * 16'h2111), 2'b00, 1'b1);
      for (int a = 0; a < NW; a++) begin
         for (int wm = 1; wm < 3; wm++) begin
            do_write(AW'(a), 16'hC0DE + 16'(a * 16'h0905) + 16'(wm * 16'h3131), 2'(wm), 1'b1);
            for (int rm = 0; rm < 4; rm++) chk_read(AW'(a), 2'(rm), "R1 R2 lane sweep");
         end
      end

      // R4 write strobe low mutes outputs even with read enable and selects
      addr = 3'd5; wdata = 16'hBEEF; sel_n = 2'b00; wr_n = 1'b0; rd_n = 1'b0;
      #1;
      check("R4 drive muted", {30'd0, drive}, 32'd0);
      check("R4 data muted", {16'd0, rdata}, 32'd0);
      step(1);
      wr_n = 1'b1; sel_n = 2'b11; rd_n = 1'b1;
      step(1);
      mdl[5] = 16'hBEEF;
      chk_read(3'd5, 2'b00, "R4 write still lands");

      // R3 select rise ends write; no restart until strobe goes high
      addr = 3'd2; wdata = 16'hA1A2; sel_n = 2'b00; wr_n = 1'b0;
      step(1);
      sel_n = 2'b11;
      step(1);
      sel_n = 2'b00; wdata = 16'h5555;
      step(2);
      wr_n = 1'b1; sel_n = 2'b11;
      step(1);
      mdl[2] = 16'hA1A2;
      chk_read(3'd2, 2'b00, "R3 select-ended write");
      // R3 one lane dropping ends the whole write
      addr = 3'd3; wdata = 16'h7E7E; sel_n = 2'b00; wr_n = 1'b0;
      step(1);
      sel_n = 2'b10; wdata = 16'h0101;
      step(2);
      wr_n = 1'b1; sel_n = 2'b11;
      step(1);
      mdl[3] = 16'h7E7E;
      chk_read(3'd3, 2'b00, "R3 lane-drop ends write");

      // R5 supply below operating: protected within FAIL_DLY, writes ignored
      set_pwr(1'b0, 1'b0, 1'b0);
      step(3);
      check("R5 mode left normal", {30'd0, mode}, 32'd2);
      chk_dark(3'd2, "R5 outputs dark");
      do_write(3'd2, 16'hDEAD, 2'b00, 1'b0);
      set_pwr(1'b1, 1'b0, 1'b0);
      step(6);
      check("R7 recovery hold", {30'd0, mode}, 32'd2);
      step(1);
      check("R7 normal after recovery", {30'd0, mode}, 32'd1);
      chk_read(3'd2, 2'b00, "R5 write ignored while protected");

      // R5 protect flag alone also protects
      set_pwr(1'b1, 1'b1, 1'b0);
      step(3);
      check("R5 protect flag", {30'd0, mode}, 32'd2);
      set_pwr(1'b1, 1'b0, 1'b0);
      step(7);
      check("R7 normal after protect flag", {30'd0, mode}, 32'd1);

      // R6 backup sequence, R9 retention
      set_pwr(1'b0, 1'b1, 1'b1);
      step(3);
      check("R6 backup on", {31'd0, bkp}, 32'd1);
      check("R10 backup code", {30'd0, mode}, 32'd3);
      chk_dark(3'd4, "R6 outputs dark in backup");
      set_pwr(1'b0, 1'b1, 1'b0);
      step(3);
      check("R6 backup off", {31'd0, bkp}, 32'd0);
      check("R6 back to protected", {30'd0, mode}, 32'd2);
      set_pwr(1'b1, 1'b0, 1'b0);
      step(6);
      check("R8 no reseal", {30'd0, mode}, 32'd2);
      step(1);
      check("R7 normal after backup", {30'd0, mode}, 32'd1);
      check("R9 valid retained", {31'd0, valid}, 32'd1);
      for (int a = 0; a < NW; a++) chk_read(AW'(a), 2'b00, "R9 contents retained");

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule